// File: doc/BRIEF.md
# Two-Stage Translation Sequencer

This block steers a single memory access from a hart through address translation. On accepting a request it decides whether the access needs one translation pass or a nested pair. A nested pair is a guest pass followed by a second pass that maps the guest-physical result. It issues each pass as a request on an external page-walk port and waits for the answer. It then asks an external protection unit about the final physical address only. The access ends in one of three ways: a TLB fill pulse, a probe miss pulse, or a fault that names the failing stage and carries the matching address.

Nesting is chosen when virtualisation is active. It is also chosen for loads and stores from machine mode or from non-virtualised supervisor mode when that mode's pair of status override bits is set and the hypervisor extension is enabled. The walker and the protection unit sit outside the block. Only one access is in flight at a time, and a pending fault blocks new requests until it is acknowledged.

Top module: `tsq_top`

## Requirements
- R1: `req_ready` is high only when no access is in flight and no fault is pending, and a request is taken only while it is high.
- R2: With virtualisation off and no override active, exactly one walk is issued, with `walk_stage` = 0 on the request address.
- R3: With `virt_on` = 1, a first walk with `walk_stage` = 1 goes out on the request address. A second walk with `walk_stage` = 2 then goes out on the full address returned by the first walk. A walk request holds its stage and address until `walk_ready`.
- R4: Privilege encoding is 0 user, 1 supervisor, 3 machine, and access encoding is 0 fetch, 1 load, 2 store. In machine mode with `hyp_en` set, a load or store with both `m_mprv` and `m_mpv` set is nested. A fetch under the same conditions is single-stage.
- R5: In supervisor mode with `virt_on` = 0, a load or store with `hyp_en`, `h_sprv` and `h_spv` all set is nested. With `hyp_en` = 0 the same access is single-stage.
- R6: A failed first walk of a nested access issues no second walk. It faults with `flt_stage` = 0 and `flt_addr` equal to the request address.
- R7: A failed second walk faults with `flt_stage` = 1. Its `flt_addr` is the page part (bits above PG_W) of the first walk's result joined with the request address's low PG_W bits.
- R8: The protection check is issued exactly once, on the last walk's result, and only if every walk succeeded. A denial faults as a failure of the last stage: nested gives the R7 stage and address, single gives stage 0 and the request address.
- R9: With `req_probe` set, any failure gives a one-cycle `miss_valid` pulse and raises no fault.
- R10: On success, `fill_valid` pulses for one cycle. It carries the page-aligned request address, the page-aligned last walk result, the last walk's permissions and the request's context index.
- R11: A fault holds `flt_valid`, `flt_acc` (the access encoding of R4), `flt_stage` and `flt_addr` steady until `flt_ack`. It clears on the cycle after the ack, and `req_ready` returns at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_vaddr | input | ADDR_W | Virtual address of the access |
| req_acc | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| req_probe | input | 1 | Probe: report miss instead of fault |
| req_ctx | input | CTX_W | Translation-context index |
| priv | input | 2 | Privilege: 0 U, 1 S, 3 M |
| virt_on | input | 1 | Virtualisation active |
| hyp_en | input | 1 | Hypervisor extension enabled |
| m_mprv | input | 1 | Machine modify-privilege bit |
| m_mpv | input | 1 | Machine previous-virtualisation bit |
| h_sprv | input | 1 | Hypervisor-status supervisor modify-privilege bit |
| h_spv | input | 1 | Hypervisor-status supervisor previous-virtualisation bit |
| walk_valid | output | 1 | Walk request |
| walk_ready | input | 1 | Walker accepts request |
| walk_stage | output | 2 | 0 single, 1 guest first, 2 second |
| walk_addr | output | ADDR_W | Address to translate |
| walk_acc | output | 2 | Access type of the walk |
| walk_rsp_valid | input | 1 | Walk response present |
| walk_rsp_ok | input | 1 | Walk succeeded |
| walk_rsp_paddr | input | ADDR_W | Translated address |
| walk_rsp_perm | input | PERM_W | Permission bits |
| pmp_valid | output | 1 | Protection query |
| pmp_addr | output | ADDR_W | Final physical address queried |
| pmp_acc | output | 2 | Access type queried |
| pmp_rsp_valid | input | 1 | Protection answer present |
| pmp_rsp_allow | input | 1 | Access allowed |
| fill_valid | output | 1 | TLB fill pulse |
| fill_vpage | output | ADDR_W | Page-aligned virtual address |
| fill_ppage | output | ADDR_W | Page-aligned physical address |
| fill_perm | output | PERM_W | Permissions |
| fill_ctx | output | CTX_W | Context index |
| miss_valid | output | 1 | Probe miss pulse |
| flt_valid | output | 1 | Fault pending |
| flt_acc | output | 2 | Faulting access type |
| flt_stage | output | 1 | 0 guest/first level, 1 hypervisor/second level |
| flt_addr | output | ADDR_W | Fault address |
| flt_ack | input | 1 | Fault acknowledge |

## Verification
The assertions assume three things about the environment. The walker raises `walk_rsp_valid` only after it has accepted a request and before it accepts another one. The protection unit answers only a query that is pending. `flt_ack` is raised only while a fault is held. The bench responders keep to these rules by construction. The walker answers once per accepted request, after a random delay of zero to two cycles, and varies `walk_ready`. The protection unit answers on the cycle after it sees the query. The ack is driven only after `flt_valid` has been observed.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2} acc_e;
  typedef enum logic [1:0] {STG_HOST = 2'd0, STG_GUEST = 2'd1, STG_NEST2 = 2'd2} wstage_e;
  typedef enum logic [2:0] {ST_IDLE, ST_WREQ, ST_WRSP, ST_PCHK, ST_FAIL, ST_HOLD} seq_e;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;
endpackage

// File: rtl/tsq_mode_sel.sv
module tsq_mode_sel
  import tsq_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       virt_on,
  input  logic       hyp_en,
  input  logic       m_mprv,
  input  logic       m_mpv,
  input  logic       h_sprv,
  input  logic       h_spv,
  input  logic [1:0] acc,
  output logic       nested
);
  logic data_acc;
  logic m_ovr;
  logic s_ovr;

  always_comb begin
    data_acc = (acc != ACC_FETCH);
    m_ovr    = (priv == PRIV_M) && m_mprv && m_mpv;
    s_ovr    = (priv == PRIV_S) && !virt_on && h_sprv && h_spv;
    nested   = virt_on || (hyp_en && data_acc && (m_ovr || s_ovr));
  end
endmodule

// File: rtl/tsq_walk_fsm.sv
module tsq_walk_fsm
  import tsq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PG_W   = 12,
  parameter int PERM_W = 3,
  parameter int CTX_W  = 3
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic              req_probe,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic              nested_in,
  input  logic              virt_in,
  output logic              walk_valid,
  input  logic              walk_ready,
  output logic [1:0]        walk_stage,
  output logic [ADDR_W-1:0] walk_addr,
  output logic [1:0]        walk_acc,
  input  logic              walk_rsp_valid,
  input  logic              walk_rsp_ok,
  input  logic [ADDR_W-1:0] walk_rsp_paddr,
  input  logic [PERM_W-1:0] walk_rsp_perm,
  output logic              pmp_valid,
  output logic [ADDR_W-1:0] pmp_addr,
  output logic [1:0]        pmp_acc,
  input  logic              pmp_rsp_valid,
  input  logic              pmp_rsp_allow,
  input  logic              flt_ack,
  output logic              fill_set,
  output logic              miss_set,
  output logic              flt_set,
  output logic [ADDR_W-1:0] cur_vaddr,
  output logic [ADDR_W-1:0] cur_paddr,
  output logic [PERM_W-1:0] cur_perm,
  output logic [CTX_W-1:0]  cur_ctx,
  output logic [1:0]        cur_acc,
  output logic              cur_stage2,
  output logic [ADDR_W-1:0] cur_faddr
);
  localparam int HI_W = ADDR_W - PG_W;

  seq_e              state;
  wstage_e           stage_q;
  logic [ADDR_W-1:0] vaddr_q, wa_q, ipa_q, pa_q;
  logic [PERM_W-1:0] perm_q;
  logic [CTX_W-1:0]  ctx_q;
  logic [1:0]        acc_q;
  logic              probe_q, nested_q, virt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      stage_q  <= STG_HOST;
      vaddr_q  <= '0;
      wa_q     <= '0;
      ipa_q    <= '0;
      pa_q     <= '0;
      perm_q   <= '0;
      ctx_q    <= '0;
      acc_q    <= ACC_FETCH;
      probe_q  <= 1'b0;
      nested_q <= 1'b0;
      virt_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          vaddr_q  <= req_vaddr;
          wa_q     <= req_vaddr;
          acc_q    <= req_acc;
          probe_q  <= req_probe;
          ctx_q    <= req_ctx;
          nested_q <= nested_in;
          virt_q   <= virt_in;
          stage_q  <= nested_in ? STG_GUEST : STG_HOST;
          state    <= ST_WREQ;
        end
        ST_WREQ: if (walk_ready) state <= ST_WRSP;
        ST_WRSP: if (walk_rsp_valid) begin
          if (!walk_rsp_ok) begin
            state <= ST_FAIL;
          end else if (stage_q == STG_GUEST) begin
            ipa_q   <= walk_rsp_paddr;
            wa_q    <= walk_rsp_paddr;
            stage_q <= STG_NEST2;
            state   <= ST_WREQ;
          end else begin
            pa_q   <= walk_rsp_paddr;
            perm_q <= walk_rsp_perm;
            state  <= ST_PCHK;
          end
        end
        ST_PCHK: if (pmp_rsp_valid) state <= pmp_rsp_allow ? ST_IDLE : ST_FAIL;
        ST_FAIL: state <= probe_q ? ST_IDLE : ST_HOLD;
        ST_HOLD: if (flt_ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready  = (state == ST_IDLE);
    walk_valid = (state == ST_WREQ);
    walk_stage = stage_q;
    walk_addr  = wa_q;
    walk_acc   = acc_q;
    pmp_valid  = (state == ST_PCHK);
    pmp_addr   = pa_q;
    pmp_acc    = acc_q;
    fill_set   = (state == ST_PCHK) && pmp_rsp_valid && pmp_rsp_allow;
    miss_set   = (state == ST_FAIL) && probe_q;
    flt_set    = (state == ST_FAIL) && !probe_q;
    cur_vaddr  = vaddr_q;
    cur_paddr  = pa_q;
    cur_perm   = perm_q;
    cur_ctx    = ctx_q;
    cur_acc    = acc_q;
    cur_stage2 = (stage_q == STG_NEST2);
    cur_faddr  = cur_stage2 ? {ipa_q[ADDR_W-1 -: HI_W], vaddr_q[PG_W-1:0]} : vaddr_q;
  end

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !walk_valid && !pmp_valid); // R1
  AST_WALK_HELD: assert property (@(posedge clk) disable iff (rst)
    walk_valid && !walk_ready |=> walk_valid && $stable(walk_addr) && $stable(walk_stage)); // R3
  AST_FETCH_NOT_NESTED: assert property (@(posedge clk) disable iff (rst)
    walk_valid && walk_stage == STG_GUEST && walk_acc == ACC_FETCH |-> virt_q); // R4
  AST_NO_WALK_AFTER_FAIL: assert property (@(posedge clk) disable iff (rst)
    state == ST_WRSP && walk_rsp_valid && !walk_rsp_ok |=> !walk_valid && !pmp_valid); // R6
  AST_PMP_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    pmp_valid |-> (nested_q ? stage_q == STG_NEST2 : stage_q == STG_HOST)); // R8
endmodule

// File: rtl/tsq_result.sv
module tsq_result #(
  parameter int ADDR_W = 32,
  parameter int PG_W   = 12,
  parameter int PERM_W = 3,
  parameter int CTX_W  = 3
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_set,
  input  logic              miss_set,
  input  logic              flt_set,
  input  logic              flt_ack,
  input  logic [ADDR_W-1:0] cur_vaddr,
  input  logic [ADDR_W-1:0] cur_paddr,
  input  logic [PERM_W-1:0] cur_perm,
  input  logic [CTX_W-1:0]  cur_ctx,
  input  logic [1:0]        cur_acc,
  input  logic              cur_stage2,
  input  logic [ADDR_W-1:0] cur_faddr,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_vpage,
  output logic [ADDR_W-1:0] fill_ppage,
  output logic [PERM_W-1:0] fill_perm,
  output logic [CTX_W-1:0]  fill_ctx,
  output logic              miss_valid,
  output logic              flt_valid,
  output logic [1:0]        flt_acc,
  output logic              flt_stage,
  output logic [ADDR_W-1:0] flt_addr
);
  localparam int HI_W = ADDR_W - PG_W;
  localparam logic [PG_W-1:0] PG_ZERO = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_valid <= 1'b0;
      fill_vpage <= '0;
      fill_ppage <= '0;
      fill_perm  <= '0;
      fill_ctx   <= '0;
      miss_valid <= 1'b0;
      flt_valid  <= 1'b0;
      flt_acc    <= '0;
      flt_stage  <= 1'b0;
      flt_addr   <= '0;
    end else begin
      fill_valid <= fill_set;
      miss_valid <= miss_set;
      if (fill_set) begin
        fill_vpage <= {cur_vaddr[ADDR_W-1 -: HI_W], PG_ZERO};
        fill_ppage <= {cur_paddr[ADDR_W-1 -: HI_W], PG_ZERO};
        fill_perm  <= cur_perm;
        fill_ctx   <= cur_ctx;
      end
      if (flt_set) begin
        flt_valid <= 1'b1;
        flt_acc   <= cur_acc;
        flt_stage <= cur_stage2;
        flt_addr  <= cur_faddr;
      end else if (flt_ack) begin
        flt_valid <= 1'b0;
      end
    end
  end

  AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> fill_vpage[PG_W-1:0] == PG_ZERO && fill_ppage[PG_W-1:0] == PG_ZERO); // R10
  AST_FILL_PULSE: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> !fill_valid); // R10
  AST_MISS_NOT_FAULT: assert property (@(posedge clk) disable iff (rst)
    miss_valid |-> !fill_valid && !$rose(flt_valid)); // R9
  AST_FAULT_HELD: assert property (@(posedge clk) disable iff (rst)
    flt_valid && !flt_ack |=> flt_valid && $stable(flt_addr) && $stable(flt_stage) && $stable(flt_acc)); // R11
endmodule

// File: rtl/tsq_top.sv
module tsq_top
  import tsq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PG_W   = 12,
  parameter int PERM_W = 3,
  parameter int CTX_W  = 3
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic              req_probe,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [1:0]        priv,
  input  logic              virt_on,
  input  logic              hyp_en,
  input  logic              m_mprv,
  input  logic              m_mpv,
  input  logic              h_sprv,
  input  logic              h_spv,
  output logic              walk_valid,
  input  logic              walk_ready,
  output logic [1:0]        walk_stage,
  output logic [ADDR_W-1:0] walk_addr,
  output logic [1:0]        walk_acc,
  input  logic              walk_rsp_valid,
  input  logic              walk_rsp_ok,
  input  logic [ADDR_W-1:0] walk_rsp_paddr,
  input  logic [PERM_W-1:0] walk_rsp_perm,
  output logic              pmp_valid,
  output logic [ADDR_W-1:0] pmp_addr,
  output logic [1:0]        pmp_acc,
  input  logic              pmp_rsp_valid,
  input  logic              pmp_rsp_allow,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_vpage,
  output logic [ADDR_W-1:0] fill_ppage,
  output logic [PERM_W-1:0] fill_perm,
  output logic [CTX_W-1:0]  fill_ctx,
  output logic              miss_valid,
  output logic              flt_valid,
  output logic [1:0]        flt_acc,
  output logic              flt_stage,
  output logic [ADDR_W-1:0] flt_addr,
  input  logic              flt_ack
);
  logic              nested;
  logic              fill_set, miss_set, flt_set, cur_stage2;
  logic [ADDR_W-1:0] cur_vaddr, cur_paddr, cur_faddr;
  logic [PERM_W-1:0] cur_perm;
  logic [CTX_W-1:0]  cur_ctx;
  logic [1:0]        cur_acc;

  tsq_mode_sel u_mode (
    .priv(priv), .virt_on(virt_on), .hyp_en(hyp_en),
    .m_mprv(m_mprv), .m_mpv(m_mpv), .h_sprv(h_sprv), .h_spv(h_spv),
    .acc(req_acc), .nested(nested)
  );

  tsq_walk_fsm #(.ADDR_W(ADDR_W), .PG_W(PG_W), .PERM_W(PERM_W), .CTX_W(CTX_W)) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_probe(req_probe), .req_ctx(req_ctx),
    .nested_in(nested), .virt_in(virt_on),
    .walk_valid(walk_valid), .walk_ready(walk_ready), .walk_stage(walk_stage),
    .walk_addr(walk_addr), .walk_acc(walk_acc),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ok(walk_rsp_ok),
    .walk_rsp_paddr(walk_rsp_paddr), .walk_rsp_perm(walk_rsp_perm),
    .pmp_valid(pmp_valid), .pmp_addr(pmp_addr), .pmp_acc(pmp_acc),
    .pmp_rsp_valid(pmp_rsp_valid), .pmp_rsp_allow(pmp_rsp_allow),
    .flt_ack(flt_ack),
    .fill_set(fill_set), .miss_set(miss_set), .flt_set(flt_set),
    .cur_vaddr(cur_vaddr), .cur_paddr(cur_paddr), .cur_perm(cur_perm),
    .cur_ctx(cur_ctx), .cur_acc(cur_acc), .cur_stage2(cur_stage2), .cur_faddr(cur_faddr)
  );

  tsq_result #(.ADDR_W(ADDR_W), .PG_W(PG_W), .PERM_W(PERM_W), .CTX_W(CTX_W)) u_res (
    .clk(clk), .rst(rst),
    .fill_set(fill_set), .miss_set(miss_set), .flt_set(flt_set), .flt_ack(flt_ack),
    .cur_vaddr(cur_vaddr), .cur_paddr(cur_paddr), .cur_perm(cur_perm),
    .cur_ctx(cur_ctx), .cur_acc(cur_acc), .cur_stage2(cur_stage2), .cur_faddr(cur_faddr),
    .fill_valid(fill_valid), .fill_vpage(fill_vpage), .fill_ppage(fill_ppage),
    .fill_perm(fill_perm), .fill_ctx(fill_ctx), .miss_valid(miss_valid),
    .flt_valid(flt_valid), .flt_acc(flt_acc), .flt_stage(flt_stage), .flt_addr(flt_addr)
  );

  AST_PENDING_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    flt_valid |-> !req_ready); // R1
  AST_PROBE_SILENT: assert property (@(posedge clk) disable iff (rst)
    $rose(miss_valid) |-> !flt_valid); // R9
endmodule

// File: tb/tsq_top_test.sv
module tsq_top_test;
  localparam int AW = 32;
  localparam int PW = 3;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          req_valid = 0, req_probe = 0, virt_on = 0, hyp_en = 0;
  logic          m_mprv = 0, m_mpv = 0, h_sprv = 0, h_spv = 0;
  logic [AW-1:0] req_vaddr = '0;
  logic [1:0]    req_acc = '0, priv = '0;
  logic [CW-1:0] req_ctx = '0;
  logic          req_ready, walk_valid, pmp_valid, fill_valid, miss_valid, flt_valid, flt_stage;
  logic          walk_ready = 0, walk_rsp_valid = 0, walk_rsp_ok = 0;
  logic [AW-1:0] walk_rsp_paddr = '0;
  logic [PW-1:0] walk_rsp_perm = '0;
  logic          pmp_rsp_valid = 0, pmp_rsp_allow = 0, flt_ack = 0;
  logic [1:0]    walk_stage, walk_acc, pmp_acc, flt_acc;
  logic [AW-1:0] walk_addr, pmp_addr, fill_vpage, fill_ppage, flt_addr;
  logic [PW-1:0] fill_perm;
  logic [CW-1:0] fill_ctx;

  tsq_top uut (.*);

  int n_chk = 0, n_fail = 0;
  int t_fail_at = 0;
  logic t_deny = 0;
  int w_cnt = 0, p_cnt = 0;
  logic [1:0]    w_stg [0:3];
  logic [AW-1:0] w_adr [0:3];
  logic [AW-1:0] p_adr;

  function automatic logic [AW-1:0] xlat(input logic [1:0] s, input logic [AW-1:0] a);
    logic [19:0] k;
    k = (s == 2'd0) ? 20'h11111 : (s == 2'd1) ? 20'h0F0F0 : 20'h33CC3;
    return {a[31:12] ^ k, a[11:0] ^ 12'h5A5};
  endfunction

  task automatic chk(input logic ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // walker responder
  logic          pend = 0;
  int            dly = 0;
  logic          nx_ok;
  logic [AW-1:0] nx_pa;
  logic [PW-1:0] nx_perm;
  always @(negedge clk) begin
    if (walk_rsp_valid) walk_rsp_valid = 0;
    if (pend) begin
      if (dly == 0) begin
        walk_rsp_valid = 1; walk_rsp_ok = nx_ok; walk_rsp_paddr = nx_pa; walk_rsp_perm = nx_perm;
        pend = 0;
      end else dly--;
    end
    walk_ready = ($urandom % 4) != 0;
    if (walk_valid && walk_ready && !pend && !walk_rsp_valid) begin
      if (w_cnt < 4) begin w_stg[w_cnt] = walk_stage; w_adr[w_cnt] = walk_addr; end
      w_cnt++;
      nx_ok = (w_cnt != t_fail_at);
      nx_pa = xlat(walk_stage, walk_addr);
      nx_perm = {1'b1, walk_stage};
      pend = 1;
      dly = $urandom % 3;
    end
  end

  // protection responder
  always @(negedge clk) begin
    if (pmp_rsp_valid) pmp_rsp_valid = 0;
    else if (pmp_valid) begin
      pmp_rsp_valid = 1; pmp_rsp_allow = !t_deny; p_cnt++; p_adr = pmp_addr;
    end
  end

  task automatic run(input logic [1:0] pv, input logic vo, input logic he, input logic mp, input logic mv,
                     input logic sp, input logic sv, input logic [1:0] ac, input logic pr,
                     input logic [AW-1:0] va, input logic [CW-1:0] cx, input int fa, input logic dn);
    logic nested, fail, fstg, got_fill, got_miss, got_flt, busy_ok;
    int exp_w, exp_p;
    logic [AW-1:0] a1, fin, faddr;
    logic [PW-1:0] perm;
    @(negedge clk);
    chk(req_ready == 1, "R1 idle ready", req_ready, 1);
    w_cnt = 0; p_cnt = 0; t_fail_at = fa; t_deny = dn;
    priv = pv; virt_on = vo; hyp_en = he; m_mprv = mp; m_mpv = mv; h_sprv = sp; h_spv = sv;
    req_acc = ac; req_probe = pr; req_vaddr = va; req_ctx = cx; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    // expected
    nested = vo || (he && ac != 2'd0 && ((pv == 2'd3 && mp && mv) || (pv == 2'd1 && !vo && sp && sv)));
    a1 = xlat(nested ? 2'd1 : 2'd0, va);
    fstg = 0; faddr = va;
    if (nested) begin
      if (fa == 1) begin exp_w = 1; fail = 1; exp_p = 0; fin = a1; perm = 0; end
      else begin
        exp_w = 2; fin = xlat(2'd2, a1); perm = {1'b1, 2'd2};
        fail = (fa == 2) || dn; exp_p = (fa == 2) ? 0 : 1;
        if (fail) begin fstg = 1; faddr = {a1[31:12], va[11:0]}; end
      end
    end else begin
      exp_w = 1; fin = a1; perm = {1'b1, 2'd0};
      fail = (fa == 1) || dn; exp_p = (fa == 1) ? 0 : 1;
    end
    got_fill = 0; got_miss = 0; got_flt = 0; busy_ok = 1;
    for (int i = 0; i < 80 && !(got_fill || got_miss || got_flt); i++) begin
      got_fill = fill_valid; got_miss = miss_valid; got_flt = flt_valid;
      if (!(got_fill || got_miss || got_flt) && req_ready) busy_ok = 0;
      if (!(got_fill || got_miss || got_flt)) @(negedge clk);
    end
    chk(busy_ok, "R1 not ready in flight", busy_ok, 1);
    chk(w_cnt == exp_w, nested ? "R3/R6 walk count nested" : "R2 walk count single", w_cnt, exp_w);
    if (w_cnt >= 1) chk(w_stg[0] == (nested ? 2'd1 : 2'd0) && w_adr[0] == va,
                        (pv == 2'd3) ? "R4 first walk" : (pv == 2'd1 && !vo) ? "R5 first walk" : "R2/R3 first walk",
                        {w_stg[0], w_adr[0]}, {(nested ? 2'd1 : 2'd0), va});
    if (exp_w == 2 && w_cnt == 2) chk(w_stg[1] == 2'd2 && w_adr[1] == a1, "R3 second walk chained",
                        {w_stg[1], w_adr[1]}, {2'd2, a1});
    chk(p_cnt == exp_p && (exp_p == 0 || p_adr == fin), "R8 protection on final address",
        {p_cnt[3:0], p_adr}, {exp_p[3:0], fin});
    if (!fail) begin
      chk(got_fill && fill_vpage == {va[31:12], 12'h0} && fill_ppage == {fin[31:12], 12'h0}
          && fill_perm == perm && fill_ctx == cx, "R10 fill contents",
          {got_fill, fill_vpage, fill_ppage}, {1'b1, va[31:12], 12'h0, fin[31:12], 12'h0});
      @(negedge clk);
      chk(!fill_valid, "R10 fill single pulse", fill_valid, 0);
    end else if (pr) begin
      chk(got_miss && !flt_valid, "R9 probe miss no fault", {got_miss, flt_valid}, 2'b10);
      @(negedge clk);
      chk(!flt_valid && !miss_valid && req_ready, "R9 no fault after miss", {flt_valid, miss_valid}, 0);
    end else begin
      chk(got_flt && flt_stage == fstg && flt_addr == faddr && flt_acc == ac,
          fstg ? "R7 second stage fault" : (nested ? "R6 first stage fault" : "R8 single fault"),
          {got_flt, flt_stage, flt_acc, flt_addr}, {1'b1, fstg, ac, faddr});
      repeat (3) @(negedge clk);
      chk(flt_valid && flt_addr == faddr && !req_ready, "R11 fault held", {flt_valid, req_ready}, 2'b10);
      flt_ack = 1;
      @(negedge clk);
      flt_ack = 0;
      chk(!flt_valid && req_ready, "R11 cleared after ack", {flt_valid, req_ready}, 2'b01);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready && !walk_valid && !pmp_valid && !fill_valid && !flt_valid && !miss_valid,
        "R1 reset state", {req_ready, walk_valid, flt_valid}, 3'b100);
    // R2 single stage
    run(2'd0, 0, 1, 0, 0, 0, 0, 2'd1, 0, 32'h1234_5678, 3'd2, 0, 0);
    // R3 nested by virtualisation
    run(2'd1, 1, 1, 0, 0, 0, 0, 2'd2, 0, 32'hABCD_E123, 3'd5, 0, 0);
    // R4 machine override: store nested, fetch single
    run(2'd3, 0, 1, 1, 1, 0, 0, 2'd2, 0, 32'h0040_0FFF, 3'd1, 0, 0);
    run(2'd3, 0, 1, 1, 1, 0, 0, 2'd0, 0, 32'h0040_0FFF, 3'd1, 0, 0);
    // R5 supervisor override, and without extension
    run(2'd1, 0, 1, 0, 0, 1, 1, 2'd1, 0, 32'h8000_0010, 3'd3, 0, 0);
    run(2'd1, 0, 0, 0, 0, 1, 1, 2'd1, 0, 32'h8000_0010, 3'd3, 0, 0);
    // R6 first stage failure
    run(2'd0, 1, 0, 0, 0, 0, 0, 2'd1, 0, 32'h7777_7ABC, 3'd0, 1, 0);
    // R7 second stage failure
    run(2'd0, 1, 0, 0, 0, 0, 0, 2'd2, 0, 32'h7777_7ABC, 3'd0, 2, 0);
    // R8 denial after nested and after single
    run(2'd1, 1, 1, 0, 0, 0, 0, 2'd0, 0, 32'hFFFF_F001, 3'd7, 0, 1);
    run(2'd3, 0, 0, 0, 0, 0, 0, 2'd1, 0, 32'h0000_0001, 3'd7, 0, 1);
    // R9 probe failures
    run(2'd0, 1, 0, 0, 0, 0, 0, 2'd1, 1, 32'h1357_9BDF, 3'd4, 2, 0);
    run(2'd0, 0, 0, 0, 0, 0, 0, 2'd1, 1, 32'h1357_9BDF, 3'd4, 0, 1);
    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [1:0] pv, ac;
      int fa;
      pv = ($urandom % 3 == 0) ? 2'd0 : ($urandom % 2 == 0) ? 2'd1 : 2'd3;
      ac = 2'($urandom % 3);
      fa = ($urandom % 4 == 0) ? int'($urandom % 2) + 1 : 0;
      run(pv, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          ac, ($urandom % 5 == 0), $urandom, 3'($urandom), fa, ($urandom % 6 == 0));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule